// File: doc/BRIEF.md
# Shadowed Scaler Control Register Bank

This block holds the control settings of a video scaler behind a small write/read bus addressed by an 8-bit subaddress. One control register selects the scaling mode and the output formats. Five parameter registers carry the picture-in-picture settings, the active line length and three scaling coefficients. A write to a parameter register goes into a staging copy, and the datapath keeps its current value. A write to the control register copies every staged value into the active set in the same clock edge. A host can therefore change several parameters and apply them together with one final write.

The active values drive the scaler datapath directly. The datapath also receives a one-cycle commit strobe. A sticky update flag shows whether the active set matches what was last staged. Coefficient writes are clamped into their legal range before staging. Reserved bits are always stored and read as zero.

Top module: `scaler_shadow_regs`

## Requirements
- R1: After reset the active line length is 1080, the compression and expansion coefficients are both 1024, the nonlinear coefficient is 0, all mode and picture-in-picture fields are 0, and the update flag and the commit strobe are low.
- R2: A write to subaddress 0x41 to 0x45 leaves every active output unchanged, and a read of that subaddress returns the newly staged value.
- R3: A write to subaddress 0x40 makes all five staged values active on the next clock edge, together with the mode fields taken from the written data.
- R4: In the 0x40 register, bits [1:0] are the scaling mode (0 linear, 1 and 2 the two nonlinear curves, 3 reserved), bit 3 selects 4:1:1 colour when set, bit 4 is bypass, bit 6 selects the composite luma range when set, and bit 7 selects signed chroma when set. Bits 2, 5 and 10:8 read as 0.
- R5: A compression coefficient (subaddress 0x43) below 1024 is stored as 1024. Values from 1024 to 4095 are stored unchanged.
- R6: An expansion coefficient (subaddress 0x44) below 256 is stored as 256, and one above 1024 is stored as 1024. Values in between are stored unchanged.
- R7: In the 0x41 register, bits [1:0] are the horizontal downsampling code, bits [3:2] are the vertical compression code, bit 4 enables the vertical filter and bit 5 selects the interlace offset. Bits 11:6 read as 0.
- R8: Every write to 0x40 raises the commit strobe for exactly the one cycle after the write edge. The strobe is low at all other times.
- R9: The update flag, visible as bit 11 of a 0x40 read and on its own output, is set by a write to 0x40 and cleared by any write to 0x41 to 0x45.
- R10: Writes to subaddresses outside 0x40 to 0x45 change no register or output, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write enable for one cycle |
| busAddr | input | 8 | Subaddress for write and read |
| busWrData | input | 12 | Write data |
| busRdData | output | 12 | Read data for busAddr (combinational) |
| scaleMode | output | 2 | Active scaling mode |
| colour411 | output | 1 | Active 4:1:1 colour select |
| scalerBypass | output | 1 | Active bypass |
| lumaCvbs | output | 1 | Active composite luma range select |
| chromaSigned | output | 1 | Active signed chroma select |
| pipDownsamp | output | 2 | Active horizontal downsampling code |
| pipCompress | output | 2 | Active vertical compression code |
| pipFilterEn | output | 1 | Active vertical filter enable |
| pipInterlaceOfs | output | 1 | Active interlace offset select |
| lineLen | output | 12 | Active line length in pixels |
| compCoef | output | 12 | Active compression coefficient |
| expCoef | output | 12 | Active expansion coefficient |
| nonlinCoef | output | 12 | Active nonlinear coefficient |
| commitPulse | output | 1 | One-cycle strobe after a commit |
| updateDone | output | 1 | Update flag |

## Verification
The assertions assume that busWrEn is a clean level sampled on the rising edge, with busAddr and busWrData valid whenever it is high. They also assume that the only way to reach the block is a write, so every change seen on an active output comes from a commit edge. The bench drives every input on the falling edge and holds each write for exactly one cycle. It samples outputs and the combinational read path on the falling edge as well, so each stimulus meets these assumptions.

// File: rtl/scaler_regs_pkg.sv
package scaler_regs_pkg;
  localparam int DATA_W    = 12;
  localparam int ADDR_W    = 8;
  localparam int NUM_PARAM = 5;
  localparam logic [ADDR_W-1:0] MODE_ADDR = 8'h40;

  // parameter slot indices, slot i sits at MODE_ADDR + 1 + i
  localparam int IDX_PIP  = 0;
  localparam int IDX_LEN  = 1;
  localparam int IDX_COMP = 2;
  localparam int IDX_EXP  = 3;
  localparam int IDX_NL   = 4;

  localparam logic [DATA_W-1:0] LEN_DEFAULT  = 12'd1080;
  localparam logic [DATA_W-1:0] COMP_MIN     = 12'd1024;
  localparam logic [DATA_W-1:0] COMP_MAX     = 12'd4095;
  localparam logic [DATA_W-1:0] EXP_MIN      = 12'd256;
  localparam logic [DATA_W-1:0] EXP_MAX      = 12'd1024;
  localparam logic [DATA_W-1:0] PIP_MASK     = 12'h03F;

  typedef struct packed {
    logic                 modeWr;
    logic [NUM_PARAM-1:0] paramWr;
  } strobe_t;

  typedef struct packed {
    logic       chromaSigned;
    logic       lumaCvbs;
    logic       bypass;
    logic       colour411;
    logic [1:0] scaleMode;
  } mode_t;

  function automatic logic [DATA_W-1:0] paramDefault(input int idx);
    case (idx)
      IDX_LEN:  return LEN_DEFAULT;
      IDX_COMP: return COMP_MIN;
      IDX_EXP:  return EXP_MAX;
      default:  return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] paramLow(input int idx);
    case (idx)
      IDX_COMP: return COMP_MIN;
      IDX_EXP:  return EXP_MIN;
      default:  return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] paramHigh(input int idx);
    case (idx)
      IDX_COMP: return COMP_MAX;
      IDX_EXP:  return EXP_MAX;
      default:  return '1;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] paramMask(input int idx);
    return (idx == IDX_PIP) ? PIP_MASK : '1;
  endfunction
endpackage

// File: rtl/scaler_regs_ctrl.sv
module scaler_regs_ctrl
  import scaler_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strobe,
  output logic              commitPulse,
  output logic              updateDone
);
  strobe_t strobeNext;

  always_comb begin
    strobeNext.modeWr = wrEn && (addr == MODE_ADDR);
  end

  for (genvar i = 0; i < NUM_PARAM; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] SLOT_ADDR = MODE_ADDR + ADDR_W'(i + 1);
    always_comb strobeNext.paramWr[i] = wrEn && (addr == SLOT_ADDR);
  end

  assign strobe = strobeNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      commitPulse <= 1'b0;
      updateDone  <= 1'b0;
    end else begin
      commitPulse <= strobeNext.modeWr;
      if (strobeNext.modeWr)
        updateDone <= 1'b1;
      else if (|strobeNext.paramWr)
        updateDone <= 1'b0;
    end
  end
endmodule

// File: rtl/scaler_regs_datapath.sv
module scaler_regs_datapath
  import scaler_regs_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  strobe_t                             strobe,
  input  logic [DATA_W-1:0]                   wrData,
  input  logic [ADDR_W-1:0]                   rdAddr,
  input  logic                                updateDone,
  output mode_t                               modeAct,
  output logic [NUM_PARAM-1:0][DATA_W-1:0]    paramAct,
  output logic [DATA_W-1:0]                   rdData
);
  logic [NUM_PARAM-1:0][DATA_W-1:0] paramStage;
  mode_t                            modeNext;

  always_comb begin
    modeNext.scaleMode    = wrData[1:0];
    modeNext.colour411    = wrData[3];
    modeNext.bypass       = wrData[4];
    modeNext.lumaCvbs     = wrData[6];
    modeNext.chromaSigned = wrData[7];
  end

  always_ff @(posedge clk) begin
    if (!rstN)              modeAct <= '0;
    else if (strobe.modeWr) modeAct <= modeNext;
  end

  for (genvar i = 0; i < NUM_PARAM; i++) begin : g_slot
    localparam logic [DATA_W-1:0] DEF  = paramDefault(i);
    localparam logic [DATA_W-1:0] LOW  = paramLow(i);
    localparam logic [DATA_W-1:0] HIGH = paramHigh(i);
    localparam logic [DATA_W-1:0] MSK  = paramMask(i);
    logic [DATA_W-1:0] fitted;

    always_comb begin
      if (wrData < LOW)       fitted = LOW;
      else if (wrData > HIGH) fitted = HIGH;
      else                    fitted = wrData & MSK;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        paramStage[i] <= DEF;
        paramAct[i]   <= DEF;
      end else begin
        if (strobe.paramWr[i]) paramStage[i] <= fitted;
        if (strobe.modeWr)     paramAct[i]   <= paramStage[i];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == MODE_ADDR) begin
      rdData = {updateDone, 3'b000, modeAct.chromaSigned, modeAct.lumaCvbs, 1'b0,
                modeAct.bypass, modeAct.colour411, 1'b0, modeAct.scaleMode};
    end else begin
      for (int i = 0; i < NUM_PARAM; i++)
        if (rdAddr == MODE_ADDR + ADDR_W'(i + 1)) rdData = paramStage[i];
    end
  end
endmodule

// File: rtl/scaler_shadow_regs.sv
module scaler_shadow_regs
  import scaler_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [7:0]  busAddr,
  input  logic [11:0] busWrData,
  output logic [11:0] busRdData,
  output logic [1:0]  scaleMode,
  output logic        colour411,
  output logic        scalerBypass,
  output logic        lumaCvbs,
  output logic        chromaSigned,
  output logic [1:0]  pipDownsamp,
  output logic [1:0]  pipCompress,
  output logic        pipFilterEn,
  output logic        pipInterlaceOfs,
  output logic [11:0] lineLen,
  output logic [11:0] compCoef,
  output logic [11:0] expCoef,
  output logic [11:0] nonlinCoef,
  output logic        commitPulse,
  output logic        updateDone
);
  strobe_t                          strobe;
  mode_t                            modeAct;
  logic [NUM_PARAM-1:0][DATA_W-1:0] paramAct;

  scaler_regs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .addr(busAddr),
    .strobe(strobe), .commitPulse(commitPulse), .updateDone(updateDone)
  );

  scaler_regs_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .rdAddr(busAddr), .updateDone(updateDone), .modeAct(modeAct),
    .paramAct(paramAct), .rdData(busRdData)
  );

  assign scaleMode       = modeAct.scaleMode;
  assign colour411       = modeAct.colour411;
  assign scalerBypass    = modeAct.bypass;
  assign lumaCvbs        = modeAct.lumaCvbs;
  assign chromaSigned    = modeAct.chromaSigned;
  assign pipDownsamp     = paramAct[IDX_PIP][1:0];
  assign pipCompress     = paramAct[IDX_PIP][3:2];
  assign pipFilterEn     = paramAct[IDX_PIP][4];
  assign pipInterlaceOfs = paramAct[IDX_PIP][5];
  assign lineLen         = paramAct[IDX_LEN];
  assign compCoef        = paramAct[IDX_COMP];
  assign expCoef         = paramAct[IDX_EXP];
  assign nonlinCoef      = paramAct[IDX_NL];
endmodule

// File: rtl/scaler_shadow_regs_chk.sv
module scaler_shadow_regs_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busWrEn,
  input logic [7:0]  busAddr,
  input logic [11:0] busRdData,
  input logic [11:0] lineLen,
  input logic [11:0] compCoef,
  input logic [11:0] expCoef,
  input logic [11:0] nonlinCoef,
  input logic [1:0]  scaleMode,
  input logic        commitPulse,
  input logic        updateDone
);
  // R8
  commit_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 8'h40) |=> commitPulse);
  // R8
  commit_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> $past(busWrEn && busAddr == 8'h40));
  // R2
  active_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commitPulse |-> ($stable(lineLen) && $stable(compCoef) && $stable(expCoef)
                      && $stable(nonlinCoef) && $stable(scaleMode)));
  // R5
  comp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    compCoef >= 12'd1024);
  // R6
  exp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    expCoef >= 12'd256 && expCoef <= 12'd1024);
  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> updateDone);
  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr >= 8'h41 && busAddr <= 8'h45) |=> !updateDone);
  // R4
  mode_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 8'h40) |-> (busRdData[10:8] == 3'b000 && !busRdData[5] && !busRdData[2]));
  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr < 8'h40 || busAddr > 8'h45) |-> busRdData == 12'h000);
endmodule

bind scaler_shadow_regs scaler_shadow_regs_chk u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busRdData(busRdData), .lineLen(lineLen), .compCoef(compCoef),
  .expCoef(expCoef), .nonlinCoef(nonlinCoef), .scaleMode(scaleMode),
  .commitPulse(commitPulse), .updateDone(updateDone)
);

// File: tb/scaler_shadow_regs_tb.sv
module scaler_shadow_regs_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [11:0] busWrData = 12'h000;
  logic [11:0] busRdData, lineLen, compCoef, expCoef, nonlinCoef;
  logic [1:0]  scaleMode, pipDownsamp, pipCompress;
  logic        colour411, scalerBypass, lumaCvbs, chromaSigned;
  logic        pipFilterEn, pipInterlaceOfs, commitPulse, updateDone;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  scaler_shadow_regs u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .scaleMode(scaleMode),
    .colour411(colour411), .scalerBypass(scalerBypass), .lumaCvbs(lumaCvbs),
    .chromaSigned(chromaSigned), .pipDownsamp(pipDownsamp),
    .pipCompress(pipCompress), .pipFilterEn(pipFilterEn),
    .pipInterlaceOfs(pipInterlaceOfs), .lineLen(lineLen), .compCoef(compCoef),
    .expCoef(expCoef), .nonlinCoef(nonlinCoef), .commitPulse(commitPulse),
    .updateDone(updateDone)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // write held for one cycle; returns at the following falling edge
  task automatic busWrite(input logic [7:0] a, input logic [11:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 8'h00;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [11:0] d);
    busAddr = a;
    #1;
    d = busRdData;
    busAddr = 8'h00;
  endtask

  task automatic testReset();
    logic [11:0] rd;
    check("R1 lineLen", lineLen, 1080);
    check("R1 compCoef", compCoef, 1024);
    check("R1 expCoef", expCoef, 1024);
    check("R1 nonlinCoef", nonlinCoef, 0);
    check("R1 mode fields", {scaleMode, colour411, scalerBypass, lumaCvbs, chromaSigned}, 0);
    check("R1 pip fields", {pipDownsamp, pipCompress, pipFilterEn, pipInterlaceOfs}, 0);
    check("R1 strobe and flag", {commitPulse, updateDone}, 0);
    busRead(8'h40, rd);
    check("R1 mode readback", rd, 0);
  endtask

  task automatic testStaging();
    logic [11:0] rd;
    busWrite(8'h42, 12'd720);
    busWrite(8'h45, 12'd300);
    check("R2 lineLen held", lineLen, 1080);
    check("R2 nonlinCoef held", nonlinCoef, 0);
    check("R8 no strobe on staging", commitPulse, 0);
    busRead(8'h42, rd);
    check("R2 staged lineLen readback", rd, 720);
    busRead(8'h45, rd);
    check("R2 staged nonlin readback", rd, 300);
  endtask

  task automatic testCommit();
    logic [11:0] rd;
    busWrite(8'h40, 12'h7FD);
    check("R8 strobe after commit", commitPulse, 1);
    check("R3 lineLen committed", lineLen, 720);
    check("R3 nonlinCoef committed", nonlinCoef, 300);
    check("R4 scaleMode", scaleMode, 1);
    check("R4 colour/bypass/luma/chroma", {colour411, scalerBypass, lumaCvbs, chromaSigned}, 4'hF);
    check("R9 flag set", updateDone, 1);
    busRead(8'h40, rd);
    check("R4 R9 mode readback", rd, 12'h8D9);
    @(negedge clk);
    check("R8 strobe one cycle", commitPulse, 0);
    busWrite(8'h40, 12'h002);
    check("R4 scaleMode waterglass", scaleMode, 2);
    check("R4 flags cleared", {colour411, scalerBypass, lumaCvbs, chromaSigned}, 0);
  endtask

  task automatic testClamp();
    logic [11:0] rd;
    busWrite(8'h43, 12'd500);
    check("R9 flag cleared by staging", updateDone, 0);
    busRead(8'h43, rd);
    check("R5 low clamp", rd, 1024);
    busWrite(8'h43, 12'd4095);
    busRead(8'h43, rd);
    check("R5 top of range", rd, 4095);
    busWrite(8'h43, 12'd3000);
    busRead(8'h43, rd);
    check("R5 in range", rd, 3000);
    busWrite(8'h44, 12'd100);
    busRead(8'h44, rd);
    check("R6 low clamp", rd, 256);
    busWrite(8'h44, 12'd2000);
    busRead(8'h44, rd);
    check("R6 high clamp", rd, 1024);
    busWrite(8'h44, 12'd512);
    check("R2 compCoef held", compCoef, 1024);
    busWrite(8'h40, 12'h000);
    check("R3 R5 compCoef committed", compCoef, 3000);
    check("R3 R6 expCoef committed", expCoef, 512);
    check("R9 flag set again", updateDone, 1);
  endtask

  task automatic testPip();
    logic [11:0] rd;
    busWrite(8'h41, 12'hFFF);
    busRead(8'h41, rd);
    check("R7 reserved pip bits", rd, 12'h03F);
    busWrite(8'h40, 12'h000);
    check("R7 all pip fields", {pipDownsamp, pipCompress, pipFilterEn, pipInterlaceOfs}, 6'h3F);
    busWrite(8'h41, 12'h026);
    busWrite(8'h40, 12'h000);
    check("R7 downsamp", pipDownsamp, 2);
    check("R7 compress", pipCompress, 1);
    check("R7 filter/interlace", {pipFilterEn, pipInterlaceOfs}, 2'b01);
  endtask

  task automatic testUnmapped();
    logic [11:0] rd;
    busWrite(8'h46, 12'd123);
    busWrite(8'h3F, 12'd77);
    check("R10 flag kept", updateDone, 1);
    check("R10 strobe absent", commitPulse, 0);
    busRead(8'h46, rd);
    check("R10 read 0x46", rd, 0);
    busRead(8'h3F, rd);
    check("R10 read 0x3F", rd, 0);
    busRead(8'h42, rd);
    check("R10 lineLen staged kept", rd, 720);
    busRead(8'h45, rd);
    check("R10 nonlin staged kept", rd, 300);
    check("R10 active kept", {lineLen, nonlinCoef}, {12'd720, 12'd300});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStaging();
    testCommit();
    testClamp();
    testPip();
    testUnmapped();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule